// File: doc/BRIEF.md
# Eight-Stage Parallel-In Serial Shift Register with Asynchronous Word Load

This block turns an eight-bit parallel word into a serial stream. A level-sensitive load control forces the word into the register through per-stage direct set and clear. It does this at once, without waiting for a clock edge. While the load control is high, every stage follows its parallel input bit, and the clock and the serial input are ignored.

Once the load control drops, each rising clock edge does two things. The bit on the serial input enters stage 0, and every stage passes its value one place toward stage 7. Only the three highest stages (5, 6 and 7) are brought out as taps. Stage 7 is the serial output of the word, and stages 5 and 6 show the next two bits.

The block has no reset pin. Its state is defined by the first parallel load, so a user loads a word before relying on the taps.

Top module: `pload_serializer`

## Requirements
- R1: The register has eight stages numbered 0 to 7. Stage 0 takes the serial input. The tap bus maps tap[0] to stage 5, tap[1] to stage 6 and tap[2] to stage 7.
- R2: While ld is high, tap equals par_in[7:5] (tap[2] = par_in[7]) with no clock edge needed. tap tracks any change of par_in during the load.
- R3: While ld is high, rising clock edges and ser_in have no effect. After ld falls, the register holds the word that par_in carried at that moment.
- R4: With ld low, each rising clock edge moves stage n into stage n+1 for n = 0 to 6. At the taps, tap[2:1] takes the previous tap[1:0].
- R5: A bit sampled from ser_in on a rising edge with ld low appears on tap[0] right after the fifth following edge, which is the sixth shift counted from its entry.
- R6: After eight shifting edges that carry serial bits D1 to D8 in that order, tap[2] = D1, tap[1] = D2 and tap[0] = D3.
- R7: With ld low and no rising clock edge, tap does not change, whatever ser_in does.
- R8: The hidden stages hold the loaded word. After j shifting edges following a load (1 ≤ j ≤ 5), tap[0] equals par_in bit 5−j of the loaded word.
- R9: There is no reset input. Raising ld defines the whole register state immediately, from any prior state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising-edge active |
| ld | input | 1 | Asynchronous level-sensitive parallel load, active high |
| ser_in | input | 1 | Serial bit shifted into stage 0 |
| par_in | input | 8 | Parallel word; bit n forces stage n during load |
| tap | output | 3 | Stages 5, 6, 7 on bits 0, 1, 2 |

## Verification
Load and shift can meet on the same clock edge: a rising edge can arrive while ld is still high. The bench provokes this on every loaded word, in two ways. First, it holds ld across a rising edge while flipping ser_in. Second, it rewrites par_in in the middle of the load. The edge is judged to have lost when the taps still equal the current parallel bits just after it, and when the word present at the fall of ld is the one that later shifts out bit by bit against an eight-stage reference model. The ld falling edge is always placed half a period before the next rising edge, which honours the recovery window.

// File: rtl/pload_serializer_pkg.sv
package pload_serializer_pkg;
  localparam int unsigned PLS_STAGES = 8;
  localparam int unsigned PLS_TAPS   = 3;

  typedef enum logic [1:0] {
    CELL_HOLD  = 2'b00,
    CELL_SET   = 2'b01,
    CELL_CLEAR = 2'b10
  } cell_force_e;
endpackage

// File: rtl/pls_cell.sv
module pls_cell (
  input  logic clk,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  // Direct set dominates direct clear; the clock edge only acts when neither is asserted.
  always_ff @(posedge clk or posedge set_i or posedge clr_i) begin
    if (set_i)      q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
    else            q_o <= d_i;
  end
endmodule

// File: rtl/pls_force.sv
module pls_force
  import pload_serializer_pkg::*;
#(
  parameter int unsigned STAGES = PLS_STAGES
) (
  input  logic              ld,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] set_o,
  output logic [STAGES-1:0] clr_o
);
  for (genvar n = 0; n < STAGES; n++) begin : g_force
    cell_force_e mode;
    always_comb begin
      mode = CELL_HOLD;
      if (ld) mode = par_in[n] ? CELL_SET : CELL_CLEAR;
    end
    assign set_o[n] = (mode == CELL_SET);
    assign clr_o[n] = (mode == CELL_CLEAR);
  end
endmodule

// File: rtl/pls_chain.sv
module pls_chain
  import pload_serializer_pkg::*;
#(
  parameter int unsigned STAGES = PLS_STAGES
) (
  input  logic              clk,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic [STAGES-1:0] set_i,
  input  logic [STAGES-1:0] clr_i,
  output logic [STAGES-1:0] q_o
);
  logic [STAGES-1:0] upstream;
  logic [STAGES-1:0] d_next;

  // Next-state: each stage takes its upstream neighbour when enabled, else keeps its value.
  always_comb begin
    upstream = {q_o[STAGES-2:0], ser_in};
    d_next   = shift_en ? upstream : q_o;
  end

  for (genvar n = 0; n < STAGES; n++) begin : g_stage
    pls_cell u_cell (
      .clk   (clk),
      .set_i (set_i[n]),
      .clr_i (clr_i[n]),
      .d_i   (d_next[n]),
      .q_o   (q_o[n])
    );
  end
endmodule

// File: rtl/pload_serializer.sv
module pload_serializer
  import pload_serializer_pkg::*;
#(
  parameter int unsigned STAGES = PLS_STAGES,
  parameter int unsigned TAPS   = PLS_TAPS
) (
  input  logic              clk,
  input  logic              ld,
  input  logic              ser_in,
  input  logic [STAGES-1:0] par_in,
  output logic [TAPS-1:0]   tap
);
  localparam int unsigned FIRST_TAP = STAGES - TAPS;

  logic [STAGES-1:0] force_set;
  logic [STAGES-1:0] force_clr;
  logic [STAGES-1:0] stage_q;
  logic              shift_en;

  assign shift_en = ~ld;

  pls_force #(.STAGES(STAGES)) u_force (
    .ld     (ld),
    .par_in (par_in),
    .set_o  (force_set),
    .clr_o  (force_clr)
  );

  pls_chain #(.STAGES(STAGES)) u_chain (
    .clk      (clk),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .set_i    (force_set),
    .clr_i    (force_clr),
    .q_o      (stage_q)
  );

  assign tap = stage_q[STAGES-1:FIRST_TAP];
endmodule

// File: rtl/pload_serializer_chk.sv
module pload_serializer_chk #(
  parameter int unsigned STAGES = 8,
  parameter int unsigned TAPS   = 3
) (
  input logic              clk,
  input logic              ld,
  input logic              ser_in,
  input logic [STAGES-1:0] par_in,
  input logic [TAPS-1:0]   tap
);
  localparam int unsigned FIRST_TAP = STAGES - TAPS;
  localparam int unsigned RUN_W     = $clog2(STAGES + 1) + 1;

  logic              primed = 1'b0;
  logic [RUN_W-1:0]  run;
  logic [STAGES-1:0] hist;

  always_ff @(posedge ld) primed <= 1'b1;

  // Count shifting edges since the last load began.
  always_ff @(posedge clk or posedge ld) begin
    if (ld)                             run <= '0;
    else if (run < RUN_W'(STAGES + 1))  run <= run + 1'b1;
  end

  always_ff @(posedge clk) hist <= {hist[STAGES-2:0], ser_in};

  assert_load_follows_R2: assert property (@(posedge clk) disable iff (!primed)
    ld |-> (tap == par_in[STAGES-1:FIRST_TAP]));

  assert_load_ignores_clock_R3: assert property (@(posedge clk) disable iff (!primed)
    (ld && $past(ld) && $stable(par_in)) |-> $stable(tap));

  assert_shift_moves_taps_R4: assert property (@(posedge clk) disable iff (!primed)
    (!ld && run >= 2) |-> (tap[TAPS-1:1] == $past(tap[TAPS-2:0])));

  assert_serial_arrival_R5: assert property (@(posedge clk) disable iff (!primed)
    (!ld && run >= RUN_W'(FIRST_TAP + 1)) |-> (tap[0] == hist[FIRST_TAP]));
endmodule

bind pload_serializer pload_serializer_chk #(.STAGES(STAGES), .TAPS(TAPS)) u_chk (
  .clk    (clk),
  .ld     (ld),
  .ser_in (ser_in),
  .par_in (par_in),
  .tap    (tap)
);

// File: tb/pload_serializer_test.sv
module pload_serializer_test;
  logic       clk = 1'b0;
  logic       ld = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'h00;
  logic [2:0] tap;
  logic [7:0] m;
  logic [7:0] s;
  int         tests = 0;
  int         fails = 0;
  bit         done = 1'b0;

  pload_serializer uut (
    .clk    (clk),
    .ld     (ld),
    .ser_in (ser_in),
    .par_in (par_in),
    .tap    (tap)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 256; p++) begin
      s = 8'((p * 37 + 11) & 255);
      // R9: raising ld defines the state at once, no clock edge needed
      @(negedge clk);
      ld = 1'b1;
      par_in = 8'(p);
      #1 chk("R9", tap, par_in[7:5]);
      // R3: a rising edge during load with ser_in flipped has no effect
      ser_in = ~ser_in;
      @(posedge clk);
      #2 chk("R3", tap, 3'(p >> 5));
      // R2: taps follow par_in changes during load
      @(negedge clk);
      par_in = 8'(p) ^ 8'hFF;
      #1 chk("R2", tap, ~3'(p >> 5));
      par_in = 8'(p);
      #1 chk("R2", tap, 3'(p >> 5));
      // R3: release keeps the word present at the fall of ld (R1 mapping)
      @(negedge clk);
      ld = 1'b0;
      ser_in = s[7];
      #1 chk("R3", tap, 3'(p >> 5));
      m = 8'(p);
      for (int j = 0; j < 8; j++) begin
        @(posedge clk);
        m = {m[6:0], s[7-j]};
        #2 chk("R4", tap, {m[7], m[6], m[5]});
        if (j < 5) chk("R8", {2'b00, tap[0]}, {2'b00, 1'(p >> (4 - j))});
        if (j == 5) chk("R5", {2'b00, tap[0]}, {2'b00, s[7]});
        if (j < 7) begin
          @(negedge clk);
          // R7: ser_in wiggles without an edge leave taps untouched
          ser_in = ~s[6-j];
          #1 chk("R7", tap, {m[7], m[6], m[5]});
          ser_in = s[6-j];
          #1 chk("R7", tap, {m[7], m[6], m[5]});
        end
      end
      // R6 and R1: after eight shifts the taps show D1, D2, D3
      chk("R6", tap, {s[7], s[6], s[5]});
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule